// File: doc/BRIEF.md
# Indirect Configuration Register Access Window

This block is the front end of a small configuration register space that is reached indirectly. A host first loads a pointer register with the byte offset of the register it wants. It then reads or writes a 32-bit data window, and the block carries that access through to the selected register. Byte enables on a window access are applied unchanged to the selected register. On a write, only the enabled bytes change. On a read, the disabled bytes return zero.

Two requesters share the block. The primary configuration port always wins a same-cycle collision. A sideband management port can read and write the pointer directly, but its accesses to the data window are inert. The pointer may select a register array of `NUM_REGS` words at offsets 0x000 upward. It may also select the pointer at 0x0F8 or the window itself at 0x0FC, and those two self-referencing cases have defined behaviour. Every access takes one cycle. A read returns its data on the next clock edge together with a one-cycle valid strobe.

Top module: `cfg_window_top`

## Requirements
- R1: After reset the pointer reads 0, register 0 reads 0x0001_0002, every other array register reads 0, and both read-valid outputs are low.
- R2: The pointer sits at byte offset 0x0F8 and can be read and written directly from either port. Byte enable k covers bits 8k+7:8k. Only bits 11:2 are stored, so bits 1:0 and 31:12 always read as zero.
- R3: A read presents its data on `*_rdata` with `*_rvalid` high for exactly the one cycle after the request edge. Writes raise no valid strobe.
- R4: A primary write to the window at 0x0FC updates the array register selected by the pointer (word index = pointer / 4). Only the bytes whose enables are set are changed.
- R5: A window read returns the selected register, with each byte whose enable is clear read as zero.
- R6: When the pointer holds 0x0FC, window reads return zero and window writes change no register.
- R7: When the pointer holds 0x0F8, window writes change the pointer, subject to the byte enables and the bit 11:2 storage rule. Window reads then return the pointer.
- R8: A pointer at or beyond word index `NUM_REGS` that is neither 0x0F8 nor 0x0FC makes window reads return zero and window writes ignored. A direct access to any offset other than 0x0F8 or 0x0FC also reads zero and writes nothing.
- R9: Sideband reads of the window return zero and sideband writes of the window have no effect. Sideband pointer accesses behave exactly as primary ones do.
- R10: When both ports request in the same cycle, only the primary access takes effect. The sideband access is dropped, changes nothing, and raises no `s_rvalid`.
- R11: Each array register has a write mask that window writes cannot override. Register 0 is fully read-only. Odd-numbered registers have bits 31:16 read-only at zero. Other even-numbered registers are fully writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req | input | 1 | Primary access request, one cycle per access |
| p_we | input | 1 | Primary write (1) or read (0) |
| p_addr | input | AW | Primary byte offset |
| p_be | input | 4 | Primary byte enables |
| p_wdata | input | 32 | Primary write data |
| p_rvalid | output | 1 | Primary read data valid |
| p_rdata | output | 32 | Primary read data |
| s_req | input | 1 | Sideband access request |
| s_we | input | 1 | Sideband write (1) or read (0) |
| s_addr | input | AW | Sideband byte offset |
| s_be | input | 4 | Sideband byte enables |
| s_wdata | input | 32 | Sideband write data |
| s_rvalid | output | 1 | Sideband read data valid |
| s_rdata | output | 32 | Sideband read data |

## Verification
The assertions take for granted that each request lasts one cycle and that its fields are stable around the clock edge. They also assume the default parameters keep 0x0F8 and 0x0FC above the array, so the three kinds of target never overlap. The stimulus drives every request for exactly one cycle from the falling edge. It uses the default layout throughout and mixes directed self-reference, range and collision cases with a pseudo-random sequence drawn from the same legal encodings.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;

  typedef enum logic [1:0] {RD_ZERO, RD_PTR, RD_ARR} rd_sel_e;

  // Expand byte enables into a bit mask.
  function automatic logic [DW-1:0] be_to_bits(input logic [BEW-1:0] be);
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < BEW; k++) begin
      if (be[k]) m[8*k +: 8] = 8'hFF;
    end
    return m;
  endfunction

  // Replace the bits selected by m with the new value.
  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] new_v,
                                                input logic [DW-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [DW-1:0] reg_reset_value(input int idx);
    return (idx == 0) ? 32'h0001_0002 : '0;
  endfunction

  // Writable bits per array word.
  function automatic logic [DW-1:0] reg_write_mask(input int idx);
    if (idx == 0)           return '0;
    else if (idx % 2 == 1)  return 32'h0000_FFFF;
    else                    return '1;
  endfunction
endpackage

// File: rtl/cfgwin_arbiter.sv
module cfgwin_arbiter
  import cfgwin_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic           p_req,
  input  logic           p_we,
  input  logic [AW-1:0]  p_addr,
  input  logic [BEW-1:0] p_be,
  input  logic [DW-1:0]  p_wdata,
  input  logic           s_req,
  input  logic           s_we,
  input  logic [AW-1:0]  s_addr,
  input  logic [BEW-1:0] s_be,
  input  logic [DW-1:0]  s_wdata,
  output logic           acc_valid,
  output logic           acc_we,
  output logic           acc_side,
  output logic [AW-3:0]  acc_dw,
  output logic [BEW-1:0] acc_be,
  output logic [DW-1:0]  acc_wdata
);
  logic take_side;
  logic unused_lo;

  assign take_side = s_req & ~p_req;
  assign unused_lo = ^{p_addr[1:0], s_addr[1:0]};

  always_comb begin
    acc_valid = p_req | s_req;
    acc_side  = take_side;
    if (take_side) begin
      acc_we    = s_we;
      acc_dw    = s_addr[AW-1:2];
      acc_be    = s_be;
      acc_wdata = s_wdata;
    end else begin
      acc_we    = p_we;
      acc_dw    = p_addr[AW-1:2];
      acc_be    = p_be;
      acc_wdata = p_wdata;
    end
  end
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int            AW       = 12,
  parameter int            NUM_REGS = 32,
  parameter logic [AW-1:0] PTR_OFS  = 12'h0F8,
  parameter logic [AW-1:0] WIN_OFS  = 12'h0FC
) (
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic          acc_side,
  input  logic [AW-3:0] acc_dw,
  input  logic [AW-3:0] ptr_dw,
  output logic          ptr_we,
  output logic          arr_we,
  output logic [AW-3:0] arr_dw,
  output rd_sel_e       rd_sel
);
  localparam int            DWA    = AW - 2;
  localparam logic [DWA-1:0] PTR_DW = PTR_OFS[AW-1:2];
  localparam logic [DWA-1:0] WIN_DW = WIN_OFS[AW-1:2];
  localparam logic [DWA-1:0] NREG   = DWA'(NUM_REGS);

  logic hit_ptr, hit_win, win_open;
  logic tgt_ptr, tgt_win, tgt_arr;
  logic wr_go;

  assign hit_ptr  = (acc_dw == PTR_DW);
  assign hit_win  = (acc_dw == WIN_DW);
  assign win_open = hit_win & ~acc_side;
  assign tgt_ptr  = (ptr_dw == PTR_DW);
  assign tgt_win  = (ptr_dw == WIN_DW);
  assign tgt_arr  = (ptr_dw < NREG) & ~tgt_ptr & ~tgt_win;
  assign wr_go    = acc_valid & acc_we;

  assign ptr_we = wr_go & (hit_ptr | (win_open & tgt_ptr));
  assign arr_we = wr_go & win_open & tgt_arr;
  assign arr_dw = ptr_dw;

  always_comb begin
    rd_sel = RD_ZERO;
    if (hit_ptr)                 rd_sel = RD_PTR;
    else if (win_open & tgt_ptr) rd_sel = RD_PTR;
    else if (win_open & tgt_arr) rd_sel = RD_ARR;
  end
endmodule

// File: rtl/cfgwin_ptr.sv
module cfgwin_ptr
  import cfgwin_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  wdata,
  output logic [AW-1:0]  ptr_q
);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  logic [DW-1:0] merged;
  assign merged = merge_bytes(DW'(ptr_q), wdata, be_to_bits(be));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (we) ptr_q <= merged[AW-1:0] & ALIGN;
  end

  // R2: the pointer changes only on an accepted write
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ptr_q));
endmodule

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
  import cfgwin_pkg::*;
#(
  parameter int AW       = 12,
  parameter int NUM_REGS = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-3:0]  wr_dw,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  wdata,
  input  logic [AW-3:0]  rd_dw,
  output logic [DW-1:0]  rd_data
);
  localparam int             DWA   = AW - 2;
  localparam int             IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [DWA-1:0] NREG  = DWA'(NUM_REGS);

  logic [NUM_REGS-1:0][DW-1:0] words;
  logic [DW-1:0]               be_bits;

  assign be_bits = be_to_bits(be);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    localparam logic [DW-1:0] RV = reg_reset_value(g);
    localparam logic [DW-1:0] WM = reg_write_mask(g);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= RV;
      else if (we && wr_dw == DWA'(g))
        q <= merge_bytes(q, wdata, be_bits & WM);
    end
    assign words[g] = q;

    // R11: read-only bits keep their reset value
    a_r11_ro_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~WM) == (RV & ~WM));
  end

  assign rd_data = (rd_dw < NREG) ? words[rd_dw[IDX_W-1:0]] : '0;

  // R8: the decoder never writes outside the array
  a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> wr_dw < NREG);
endmodule

// File: rtl/cfg_window_top.sv
module cfg_window_top
  import cfgwin_pkg::*;
#(
  parameter int            AW       = 12,
  parameter int            NUM_REGS = 32,
  parameter logic [AW-1:0] PTR_OFS  = 12'h0F8,
  parameter logic [AW-1:0] WIN_OFS  = 12'h0FC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_req,
  input  logic          p_we,
  input  logic [AW-1:0] p_addr,
  input  logic [3:0]    p_be,
  input  logic [31:0]   p_wdata,
  output logic          p_rvalid,
  output logic [31:0]   p_rdata,
  input  logic          s_req,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [3:0]    s_be,
  input  logic [31:0]   s_wdata,
  output logic          s_rvalid,
  output logic [31:0]   s_rdata
);
  localparam logic [AW-3:0] PTR_DW = PTR_OFS[AW-1:2];
  localparam logic [AW-3:0] WIN_DW = WIN_OFS[AW-1:2];
  localparam logic [AW-1:0] ALIGN  = ~AW'(3);

  logic           acc_valid, acc_we, acc_side;
  logic [AW-3:0]  acc_dw, arr_dw;
  logic [BEW-1:0] acc_be;
  logic [DW-1:0]  acc_wdata, arr_rd, rd_word, rd_masked;
  logic           ptr_we, arr_we;
  logic [AW-1:0]  ptr_q;
  rd_sel_e        rd_sel;

  cfgwin_arbiter #(.AW(AW)) i_arb (
    .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_be(p_be), .p_wdata(p_wdata),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_be(s_be), .s_wdata(s_wdata),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_side(acc_side), .acc_dw(acc_dw),
    .acc_be(acc_be), .acc_wdata(acc_wdata)
  );

  cfgwin_decode #(.AW(AW), .NUM_REGS(NUM_REGS), .PTR_OFS(PTR_OFS), .WIN_OFS(WIN_OFS)) i_dec (
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_side(acc_side), .acc_dw(acc_dw),
    .ptr_dw(ptr_q[AW-1:2]), .ptr_we(ptr_we), .arr_we(arr_we), .arr_dw(arr_dw),
    .rd_sel(rd_sel)
  );

  cfgwin_ptr #(.AW(AW)) i_ptr (
    .clk(clk), .rst_n(rst_n), .we(ptr_we), .be(acc_be), .wdata(acc_wdata), .ptr_q(ptr_q)
  );

  cfgwin_regfile #(.AW(AW), .NUM_REGS(NUM_REGS)) i_rf (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .wr_dw(arr_dw), .be(acc_be),
    .wdata(acc_wdata), .rd_dw(arr_dw), .rd_data(arr_rd)
  );

  always_comb begin
    unique case (rd_sel)
      RD_PTR:  rd_word = DW'(ptr_q);
      RD_ARR:  rd_word = arr_rd;
      default: rd_word = '0;
    endcase
  end
  assign rd_masked = rd_word & be_to_bits(acc_be);

  logic p_rd_go, s_rd_go;
  assign p_rd_go = p_req & ~p_we;
  assign s_rd_go = s_req & ~s_we & ~p_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rvalid <= 1'b0;
      p_rdata  <= '0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else begin
      p_rvalid <= p_rd_go;
      s_rvalid <= s_rd_go;
      if (p_rd_go) p_rdata <= rd_masked;
      if (s_rd_go) s_rdata <= rd_masked;
    end
  end

  // Named events for the assertions
  logic p_win_hit, s_win_hit, ptr_at_win, ptr_at_ptr;
  assign p_win_hit  = (p_addr[AW-1:2] == WIN_DW);
  assign s_win_hit  = (s_addr[AW-1:2] == WIN_DW);
  assign ptr_at_win = (ptr_q[AW-1:2] == WIN_DW);
  assign ptr_at_ptr = (ptr_q[AW-1:2] == PTR_DW);

  // R3: a read strobes valid on the next cycle, nothing else does
  a_r3_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    p_req && !p_we |=> p_rvalid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_req && !p_we) |=> !p_rvalid);
  // R6: window pointing at itself reads zero
  a_r6_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
    p_req && !p_we && p_win_hit && ptr_at_win |=> p_rdata == '0);
  // R7: full-width window write through a self-pointing pointer retargets it
  a_r7_retarget: assert property (@(posedge clk) disable iff (!rst_n)
    p_req && p_we && p_win_hit && ptr_at_ptr && p_be == 4'hF
    |=> ptr_q == ($past(p_wdata[AW-1:0]) & ALIGN));
  // R9: sideband window reads return zero
  a_r9_side_zero: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !s_we && !p_req && s_win_hit |=> s_rvalid && s_rdata == '0);
  // R10: a colliding sideband access raises no strobe
  a_r10_side_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    p_req && s_req |=> !s_rvalid);
endmodule

// File: tb/test_cfg_window_top.sv
module test_cfg_window_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p_req = 0, p_we = 0, s_req = 0, s_we = 0;
  logic [11:0] p_addr = 0, s_addr = 0;
  logic [3:0]  p_be = 0, s_be = 0;
  logic [31:0] p_wdata = 0, s_wdata = 0;
  logic        p_rvalid, s_rvalid;
  logic [31:0] p_rdata, s_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk; // 250 MHz

  cfg_window_top i_cfg_window_top (
    .clk(clk), .rst_n(rst_n),
    .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_be(p_be), .p_wdata(p_wdata),
    .p_rvalid(p_rvalid), .p_rdata(p_rdata),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_be(s_be), .s_wdata(s_wdata),
    .s_rvalid(s_rvalid), .s_rdata(s_rdata)
  );

  // Behavioural reference state
  logic [31:0] m_arr [32];
  logic [31:0] m_ptr;

  function automatic logic [31:0] wmask(int t);
    if (t == 0) return 32'h0;
    if (t % 2) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic mdl(input bit side, input bit we, input logic [11:0] a,
                     input logic [3:0] be, input logic [31:0] wd,
                     output logic [31:0] rd);
    logic [31:0] bm;
    int dw, t;
    bm = 0;
    for (int k = 0; k < 4; k++) if (be[k]) bm[8*k +: 8] = 8'hFF;
    dw = int'(a) / 4;
    t  = int'(m_ptr) / 4;
    rd = 0;
    if (dw == 62 || (dw == 63 && !side && t == 62)) begin
      rd = m_ptr & bm;
      if (we) m_ptr = ((m_ptr & ~bm) | (wd & bm)) & 32'h0000_0FFC;
    end else if (dw == 63 && !side && t < 32) begin
      rd = m_arr[t] & bm;
      if (we) m_arr[t] = (m_arr[t] & ~(bm & wmask(t))) | (wd & bm & wmask(t));
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit pr, input bit pw, input logic [11:0] pa,
                     input logic [3:0] pb, input logic [31:0] pd,
                     input bit sr, input bit sw, input logic [11:0] sa,
                     input logic [3:0] sb, input logic [31:0] sd,
                     input string tag);
    logic [31:0] prd, srd;
    prd = 0; srd = 0;
    p_req = pr; p_we = pw; p_addr = pa; p_be = pb; p_wdata = pd;
    s_req = sr; s_we = sw; s_addr = sa; s_be = sb; s_wdata = sd;
    if (pr) mdl(1'b0, pw, pa, pb, pd, prd);
    else if (sr) mdl(1'b1, sw, sa, sb, sd, srd);
    @(negedge clk);
    check(tag, "p_rvalid", 32'(p_rvalid), 32'(pr && !pw));
    check(tag, "s_rvalid", 32'(s_rvalid), 32'(sr && !sw && !pr));
    if (pr && !pw) check(tag, "p_rdata", p_rdata, prd);
    if (sr && !sw && !pr) check(tag, "s_rdata", s_rdata, srd);
    p_req = 0; s_req = 0;
  endtask

  task automatic pwr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
    cyc(1, 1, a, be, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic prd(input logic [11:0] a, input logic [3:0] be, input string tag);
    cyc(1, 0, a, be, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic swr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 1, a, be, d, tag);
  endtask
  task automatic srd(input logic [11:0] a, input logic [3:0] be, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 0, a, be, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < 32; i++) m_arr[i] = (i == 0) ? 32'h0001_0002 : 32'h0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "p_rvalid idle", 32'(p_rvalid), 0);
    check("R1", "s_rvalid idle", 32'(s_rvalid), 0);
    prd(12'h0F8, 4'hF, "R1");
    prd(12'h0FC, 4'hF, "R1");
    check("R1", "reg0 literal", p_rdata, 32'h0001_0002);
    // R2: direct pointer access, alignment and byte enables
    pwr(12'h0F8, 4'hF, 32'hFFFF_FFFF, "R2");
    prd(12'h0F8, 4'hF, "R2");
    check("R2", "pointer literal", p_rdata, 32'h0000_0FFC);
    pwr(12'h0F8, 4'h1, 32'h0000_0010, "R2");
    prd(12'h0F8, 4'hF, "R2");
    check("R2", "pointer byte0", p_rdata, 32'h0000_0F10);
    // R4, R3: window write and read of register 2
    pwr(12'h0F8, 4'hF, 32'h0000_0008, "R4");
    pwr(12'h0FC, 4'hF, 32'hA5A5_1234, "R4");
    prd(12'h0FC, 4'hF, "R3");
    check("R3", "reg2 literal", p_rdata, 32'hA5A5_1234);
    pwr(12'h0FC, 4'b0101, 32'h1111_2222, "R4");
    prd(12'h0FC, 4'hF, "R4");
    check("R4", "reg2 partial", p_rdata, 32'hA511_1222);
    // R5: read byte enables
    prd(12'h0FC, 4'b0011, "R5");
    check("R5", "low half only", p_rdata, 32'h0000_1222);
    prd(12'h0FC, 4'b1000, "R5");
    // R11: write masks
    pwr(12'h0F8, 4'hF, 32'h0000_0004, "R11");
    pwr(12'h0FC, 4'hF, 32'hFFFF_FFFF, "R11");
    prd(12'h0FC, 4'hF, "R11");
    check("R11", "odd reg upper ro", p_rdata, 32'h0000_FFFF);
    pwr(12'h0F8, 4'hF, 32'h0000_0000, "R11");
    pwr(12'h0FC, 4'hF, 32'h0, "R11");
    prd(12'h0FC, 4'hF, "R11");
    check("R11", "reg0 read-only", p_rdata, 32'h0001_0002);
    // R6: pointer selects the window
    pwr(12'h0F8, 4'hF, 32'h0000_00FC, "R6");
    prd(12'h0FC, 4'hF, "R6");
    pwr(12'h0FC, 4'hF, 32'hDEAD_BEEF, "R6");
    prd(12'h0F8, 4'hF, "R6");
    for (int i = 0; i < 32; i++) begin
      pwr(12'h0F8, 4'hF, 32'(i * 4), "R6");
      prd(12'h0FC, 4'hF, "R6");
    end
    // R7: pointer selects itself
    pwr(12'h0F8, 4'hF, 32'h0000_00F8, "R7");
    prd(12'h0FC, 4'hF, "R7");
    pwr(12'h0FC, 4'hF, 32'h0000_0010, "R7");
    prd(12'h0F8, 4'hF, "R7");
    check("R7", "retargeted", p_rdata, 32'h0000_0010);
    pwr(12'h0F8, 4'hF, 32'h0000_00F8, "R7");
    pwr(12'h0FC, 4'h2, 32'h0000_0100, "R7");
    prd(12'h0F8, 4'hF, "R7");
    // R8: out of range pointer and unmapped direct offsets
    pwr(12'h0F8, 4'hF, 32'h0000_0200, "R8");
    prd(12'h0FC, 4'hF, "R8");
    pwr(12'h0FC, 4'hF, 32'h5555_5555, "R8");
    pwr(12'h040, 4'hF, 32'h7777_7777, "R8");
    prd(12'h040, 4'hF, "R8");
    prd(12'h000, 4'hF, "R8");
    for (int i = 0; i < 32; i++) begin
      pwr(12'h0F8, 4'hF, 32'(i * 4), "R8");
      prd(12'h0FC, 4'hF, "R8");
    end
    // R9: sideband
    swr(12'h0F8, 4'hF, 32'h0000_0008, "R9");
    srd(12'h0F8, 4'hF, "R9");
    check("R9", "side pointer", s_rdata, 32'h0000_0008);
    srd(12'h0FC, 4'hF, "R9");
    swr(12'h0FC, 4'hF, 32'h0BAD_F00D, "R9");
    prd(12'h0FC, 4'hF, "R9");
    // R10: collisions
    cyc(1, 0, 12'h0F8, 4'hF, 0, 1, 1, 12'h0F8, 4'hF, 32'h0000_0020, "R10");
    prd(12'h0F8, 4'hF, "R10");
    check("R10", "pointer kept", p_rdata, 32'h0000_0008);
    cyc(1, 1, 12'h0FC, 4'hF, 32'h1234_5678, 1, 0, 12'h0F8, 4'hF, 0, "R10");
    cyc(1, 0, 12'h0FC, 4'hF, 0, 1, 0, 12'h0FC, 4'hF, 0, "R10");
    // Mixed pseudo-random traffic against the model
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a1, a2, pv;
      logic [31:0] d;
      lf = lf[0] ? ((lf >> 1) ^ 32'hA300_0001) : (lf >> 1);
      pv = lf[14] ? 12'h200 : lf[13] ? 12'h0F8 : lf[12] ? 12'h0FC : {5'b0, lf[8:4], 2'b0};
      case (lf[3:2])
        2'd0:    a1 = 12'h0F8;
        2'd3:    a1 = 12'h080;
        default: a1 = 12'h0FC;
      endcase
      a2 = lf[22] ? 12'h0F8 : 12'h0FC;
      d  = (a1 == 12'h0F8 || lf[21]) ? {20'h0, pv} : (lf ^ (lf << 7));
      cyc(lf[16] | ~lf[17], lf[18], a1, lf[27:24], d,
          lf[17], lf[19], a2, lf[31:28], {20'h0, pv}, "R4");
    end
    summary();
    $finish;
  end
endmodule